// File: doc/BRIEF.md
# Flash Read Wait-State and Read-While-Write Controller

This block sits between a simple request/acknowledge read port and a flash array that reports when it is busy programming or erasing. Each read that has to go to the array is held for a configurable number of extra cycles, set on a 5-bit input. That count should follow the clock rate. Use 0 below 23 MHz, 1 from 23 up to 45 MHz, 2 from 45 up to 68 MHz and 3 from 68 up to 90 MHz. After reset the system should drive a count of 2, the read-while-write policy 3'b111 and the buffer enable at 1.

A read that misses while the array is busy is handled by a 3-bit policy. When the policy's top bit is 0, the read ends at once with an error. When the top bit is 1, the read is stalled until the busy flag drops. The lower two bits then choose whether the program or erase is aborted, and whether a sticky notification flag is raised.

A one-line holding register keeps the last 128-bit line fetched from the array. It serves later reads to that line without an array access and without wait states. Clearing its enable input invalidates it.

Top module: `flash_rd_ctrl`

## Requirements
- R1: During and right after reset, rd_ack_o, rd_err_o, arr_rd_o, arr_abort_o, irq_abort_o and irq_stall_o are all 0.
- R2: A read that misses while arr_busy_i is 0 holds arr_rd_o high for exactly cfg_wait_i+1 cycles. It is acknowledged cfg_wait_i+2 cycles after the request cycle, with rd_data_o set to bits [32*k+31:32*k] of the line, where k = rd_addr_i[1:0] and arr_addr_o = rd_addr_i[15:2].
- R3: While cfg_buf_en_i is 1, a read to the line most recently filled is acknowledged in the cycle after the request, with no array access.
- R4: While cfg_buf_en_i is 0, no read hits and the holding register is invalidated. A read to the previously held line after re-enabling goes to the array.
- R5: A miss while busy with policy bit 2 equal to 0 is acknowledged in the next cycle with rd_err_o=1. It causes no array read and no abort.
- R6: Policy 3'b100 on a busy miss pulses arr_abort_o for exactly one cycle, in the cycle after the request. It also sets irq_abort_o, and the read then stalls.
- R7: Policy 3'b101 on a busy miss pulses arr_abort_o for one cycle and leaves both interrupt flags clear.
- R8: Policy 3'b110 on a busy miss sets irq_stall_o, with no abort.
- R9: Policy 3'b111 on a busy miss stalls with no abort and no interrupt flag.
- R10: A stalled read whose busy flag is first seen low in cycle h completes in cycle h+cfg_wait_i+2, counted from the request cycle, with array data.
- R11: irq_abort_o and irq_stall_o stay set until a 1 on irq_clr_i bit 0 or bit 1 respectively. When a set and a clear of the same flag fall in one cycle, the set wins.
- R12: A holding-register hit is served in one cycle even while the array is busy, under any policy, with no error and no abort.
- R13: rd_ack_o is high for one cycle per read, and rd_err_o is high only together with rd_ack_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wait_i | input | 5 | Extra wait cycles per array read |
| cfg_rww_i | input | 3 | Read-while-busy policy code |
| cfg_buf_en_i | input | 1 | Holding register enable; 0 invalidates it |
| rd_req_i | input | 1 | Read request, held until acknowledged |
| rd_addr_i | input | 16 | Word address of the read |
| rd_ack_o | output | 1 | One-cycle read completion |
| rd_err_o | output | 1 | Error response, valid with rd_ack_o |
| rd_data_o | output | 32 | Read data, valid with rd_ack_o |
| arr_busy_i | input | 1 | Array busy with program or erase |
| arr_rd_o | output | 1 | Array read in progress |
| arr_addr_o | output | 14 | Line address presented to the array |
| arr_line_i | input | 128 | Line returned by the array |
| arr_abort_o | output | 1 | One-cycle request to abort program or erase |
| irq_clr_i | input | 2 | Write-one-to-clear pulses: bit 0 abort flag, bit 1 stall flag |
| irq_abort_o | output | 1 | Sticky abort notification |
| irq_stall_o | output | 1 | Sticky stall notification |

## Verification
Two of this block's functions can fall in the same cycle.

The first pair is a holding-register hit and a busy array. The bench keeps the busy flag high and uses an error policy while it re-reads a held line. It judges that the hit still completes in one cycle with good data and no abort.

The second pair is the setting and the clearing of a sticky flag. The bench asserts the clear pulse in the same cycle as a busy miss under the aborting policy. It then expects the flag to read 1 on the next cycle, and a later lone clear to drop it.

// File: rtl/flash_rc_pkg.sv
package flash_rc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STALL  = 2'd1,
    ST_ACCESS = 2'd2
  } rc_state_e;

  typedef struct packed {
    logic stall;
    logic abort;
    logic irq_abort;
    logic irq_stall;
  } rww_act_t;
endpackage

// File: rtl/flash_rww_policy.sv
module flash_rww_policy
  import flash_rc_pkg::*;
(
  input  logic [2:0] code_i,
  output rww_act_t   act_o
);
  always_comb begin
    act_o           = '0;
    act_o.stall     = code_i[2];
    act_o.abort     = code_i[2] & ~code_i[1];
    act_o.irq_abort = (code_i == 3'b100);
    act_o.irq_stall = (code_i == 3'b110);
  end
endmodule

// File: rtl/flash_line_buf.sv
module flash_line_buf #(
  parameter int TAG_W  = 14,
  parameter int LINE_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] line_o
);
  logic              valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      line_q  <= '0;
    end else if (!en_i) begin
      valid_q <= 1'b0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      tag_q   <= fill_tag_i;
      line_q  <= fill_line_i;
    end
  end

  assign hit_o  = en_i & valid_q & (tag_q == look_tag_i);
  assign line_o = line_q;
endmodule

// File: rtl/flash_irq_flags.sv
module flash_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;  // set beats clear
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINE_W = 128,
  parameter int WS_W   = 5,
  localparam int WORDS = LINE_W / DATA_W,
  localparam int OFF_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WS_W-1:0]   cfg_wait_i,
  input  logic [2:0]        cfg_rww_i,
  input  logic              cfg_buf_en_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_ack_o,
  output logic              rd_err_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              arr_busy_i,
  output logic              arr_rd_o,
  output logic [TAG_W-1:0]  arr_addr_o,
  input  logic [LINE_W-1:0] arr_line_i,
  output logic              arr_abort_o,
  input  logic [1:0]        irq_clr_i,
  output logic              irq_abort_o,
  output logic              irq_stall_o
);
  rc_state_e         state_q;
  logic [WS_W-1:0]   cnt_q;
  logic [TAG_W-1:0]  tag_q;
  logic [OFF_W-1:0]  off_q;
  logic              ack_q, err_q, abort_q;
  logic [DATA_W-1:0] data_q;

  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic              accept, hit, fill;
  logic [LINE_W-1:0] buf_line;
  rww_act_t          act;
  logic [1:0]        irq_set, irq_flag;

  assign req_tag = rd_addr_i[ADDR_W-1:OFF_W];
  assign req_off = rd_addr_i[OFF_W-1:0];
  assign accept  = rd_req_i & ~ack_q & (state_q == ST_IDLE);
  assign fill    = (state_q == ST_ACCESS) && (cnt_q == '0);

  flash_rww_policy u_policy (
    .code_i (cfg_rww_i),
    .act_o  (act)
  );

  flash_line_buf #(
    .TAG_W  (TAG_W),
    .LINE_W (LINE_W)
  ) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (cfg_buf_en_i),
    .fill_i      (fill),
    .fill_tag_i  (tag_q),
    .fill_line_i (arr_line_i),
    .look_tag_i  (req_tag),
    .hit_o       (hit),
    .line_o      (buf_line)
  );

  // notification only on a stalled busy miss
  assign irq_set[0] = accept & ~hit & arr_busy_i & act.irq_abort;
  assign irq_set[1] = accept & ~hit & arr_busy_i & act.irq_stall;

  flash_irq_flags #(.N(2)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set),
    .clr_i  (irq_clr_i),
    .flag_o (irq_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tag_q   <= '0;
      off_q   <= '0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
      data_q  <= '0;
    end else begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          tag_q <= req_tag;
          off_q <= req_off;
          if (hit) begin
            ack_q  <= 1'b1;
            data_q <= buf_line[req_off*DATA_W +: DATA_W];
          end else if (arr_busy_i) begin
            if (!act.stall) begin
              ack_q  <= 1'b1;
              err_q  <= 1'b1;
              data_q <= '0;
            end else begin
              state_q <= ST_STALL;
              abort_q <= act.abort;
            end
          end else begin
            state_q <= ST_ACCESS;
            cnt_q   <= cfg_wait_i;
          end
        end
        ST_STALL: if (!arr_busy_i) begin
          state_q <= ST_ACCESS;
          cnt_q   <= cfg_wait_i;
        end
        ST_ACCESS: begin
          if (cnt_q == '0) begin
            ack_q   <= 1'b1;
            data_q  <= arr_line_i[off_q*DATA_W +: DATA_W];
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_ack_o    = ack_q;
  assign rd_err_o    = err_q;
  assign rd_data_o   = data_q;
  assign arr_rd_o    = (state_q == ST_ACCESS);
  assign arr_addr_o  = tag_q;
  assign arr_abort_o = abort_q;
  assign irq_abort_o = irq_flag[0];
  assign irq_stall_o = irq_flag[1];
endmodule

// File: rtl/flash_rd_ctrl_chk.sv
module flash_rd_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cfg_rww_i,
  input logic       rd_ack_o,
  input logic       rd_err_o,
  input logic       arr_rd_o,
  input logic       arr_abort_o,
  input logic [1:0] irq_clr_i,
  input logic       irq_abort_o,
  input logic       irq_stall_o
);
  // R13
  err_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> rd_ack_o);
  // R13
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |=> !rd_ack_o);
  // R2
  access_ends_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arr_rd_o) |-> (rd_ack_o && !rd_err_o));
  // R5
  err_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_o && rd_err_o) |-> !$past(arr_rd_o));
  // R6
  abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_abort_o |=> !arr_abort_o);
  // R9
  abort_policy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_abort_o |-> ($past(cfg_rww_i[2:1]) == 2'b10));
  // R11
  abort_flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_abort_o && !irq_clr_i[0]) |=> irq_abort_o);
  // R11
  stall_flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_stall_o && !irq_clr_i[1]) |=> irq_stall_o);
endmodule

bind flash_rd_ctrl flash_rd_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_rww_i   (cfg_rww_i),
  .rd_ack_o    (rd_ack_o),
  .rd_err_o    (rd_err_o),
  .arr_rd_o    (arr_rd_o),
  .arr_abort_o (arr_abort_o),
  .irq_clr_i   (irq_clr_i),
  .irq_abort_o (irq_abort_o),
  .irq_stall_o (irq_stall_o)
);

// File: tb/tb_flash_rd_ctrl.sv
module tb_flash_rd_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   cfg_wait = 5'd2;
  logic [2:0]   cfg_rww = 3'b111;
  logic         cfg_buf_en = 1'b1;
  logic         rd_req = 1'b0;
  logic [15:0]  rd_addr = '0;
  logic         rd_ack, rd_err;
  logic [31:0]  rd_data;
  logic         arr_busy = 1'b0;
  logic         arr_rd;
  logic [13:0]  arr_addr;
  logic [127:0] arr_line;
  logic         arr_abort;
  logic [1:0]   irq_clr = '0;
  logic         irq_abort, irq_stall;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  // array model: each word encodes its own word address
  always_comb
    for (int w = 0; w < 4; w++) arr_line[w*32 +: 32] = {16'hF1A5, arr_addr, 2'(w)};

  flash_rd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wait_i(cfg_wait), .cfg_rww_i(cfg_rww),
    .cfg_buf_en_i(cfg_buf_en), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_ack_o(rd_ack), .rd_err_o(rd_err), .rd_data_o(rd_data),
    .arr_busy_i(arr_busy), .arr_rd_o(arr_rd), .arr_addr_o(arr_addr),
    .arr_line_i(arr_line), .arr_abort_o(arr_abort), .irq_clr_i(irq_clr),
    .irq_abort_o(irq_abort), .irq_stall_o(irq_stall)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       en;
    logic       busy;
    logic [2:0] pol;
    logic [4:0] ws;
    logic [15:0] addr;
    logic [3:0] hold;
    logic       e_err;
    logic [5:0] e_lat;
    logic [5:0] e_nrd;
    logic       e_ab;
    logic       e_ia;
    logic       e_is;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,3'b111,5'd2,16'h0010,4'd0,1'b0,6'd4,6'd3,1'b0,1'b0,1'b0,4'd2},  // R2
    '{1'b1,1'b0,3'b111,5'd2,16'h0013,4'd0,1'b0,6'd1,6'd0,1'b0,1'b0,1'b0,4'd3},  // R3
    '{1'b1,1'b0,3'b111,5'd0,16'h0020,4'd0,1'b0,6'd2,6'd1,1'b0,1'b0,1'b0,4'd2},  // R2
    '{1'b1,1'b0,3'b111,5'd5,16'h0031,4'd0,1'b0,6'd7,6'd6,1'b0,1'b0,1'b0,4'd2},  // R2
    '{1'b1,1'b1,3'b011,5'd2,16'h0040,4'd0,1'b1,6'd1,6'd0,1'b0,1'b0,1'b0,4'd5},  // R5
    '{1'b1,1'b1,3'b100,5'd1,16'h0050,4'd3,1'b0,6'd6,6'd2,1'b1,1'b1,1'b0,4'd6},  // R6 R10
    '{1'b1,1'b1,3'b101,5'd1,16'h0060,4'd2,1'b0,6'd5,6'd2,1'b1,1'b0,1'b0,4'd7},  // R7
    '{1'b1,1'b1,3'b110,5'd0,16'h0070,4'd2,1'b0,6'd4,6'd1,1'b0,1'b0,1'b1,4'd8},  // R8
    '{1'b1,1'b1,3'b111,5'd3,16'h0080,4'd1,1'b0,6'd6,6'd4,1'b0,1'b0,1'b0,4'd9},  // R9 R10
    '{1'b1,1'b1,3'b111,5'd2,16'h0082,4'd0,1'b0,6'd1,6'd0,1'b0,1'b0,1'b0,4'd12}, // R12
    '{1'b0,1'b0,3'b111,5'd2,16'h0081,4'd0,1'b0,6'd4,6'd3,1'b0,1'b0,1'b0,4'd4},  // R4
    '{1'b1,1'b0,3'b111,5'd2,16'h0083,4'd0,1'b0,6'd4,6'd3,1'b0,1'b0,1'b0,4'd4},  // R4
    '{1'b1,1'b1,3'b000,5'd2,16'h0081,4'd0,1'b0,6'd1,6'd0,1'b0,1'b0,1'b0,4'd12}  // R12
  };

  task automatic run_vec(input vec_t v);
    int lat = 0, nrd = 0, nab = 0;
    string r;
    r = $sformatf("R%0d", v.rq);
    cfg_buf_en = v.en; cfg_rww = v.pol; cfg_wait = v.ws; arr_busy = v.busy;
    rd_addr = v.addr; rd_req = 1'b1;
    forever begin
      @(negedge clk);
      lat++;
      if (arr_rd) nrd++;
      if (arr_abort) nab++;
      if (v.hold != 0 && lat == int'(v.hold)) arr_busy = 1'b0;
      if (rd_ack || lat > 60) break;
    end
    check({r, " latency"}, lat, int'(v.e_lat));
    check({r, " err"}, int'(rd_err), int'(v.e_err));
    check({r, " array cycles"}, nrd, int'(v.e_nrd));
    check({r, " abort cycles"}, nab, int'(v.e_ab));
    check({r, " abort flag"}, int'(irq_abort), int'(v.e_ia));
    check({r, " stall flag"}, int'(irq_stall), int'(v.e_is));
    if (!v.e_err) check({r, " data"}, int'(rd_data), int'({16'hF1A5, v.addr}));
    rd_req = 1'b0; arr_busy = 1'b0; irq_clr = 2'b11;
    @(negedge clk);
    check({r, " ack one cycle (R13)"}, int'(rd_ack), 0);
    irq_clr = 2'b00;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 ack", int'(rd_ack), 0);
    check("R1 arr_rd", int'(arr_rd), 0);
    check("R1 abort", int'(arr_abort), 0);
    check("R1 irqs", int'({irq_abort, irq_stall}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ack after reset", int'({rd_ack, rd_err}), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11 sticky flag, then set and clear in one cycle
    cfg_wait = 5'd0; cfg_rww = 3'b100; arr_busy = 1'b1;
    rd_addr = 16'h0090; rd_req = 1'b1;
    @(negedge clk);
    arr_busy = 1'b0;
    lat = 0;
    while (!rd_ack && lat < 20) begin @(negedge clk); lat++; end
    rd_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 flag held", int'(irq_abort), 1);
    arr_busy = 1'b1; rd_addr = 16'h00A0; rd_req = 1'b1; irq_clr = 2'b01;
    @(negedge clk);
    irq_clr = 2'b00;
    check("R11 set wins over clear", int'(irq_abort), 1);
    check("R6 abort pulse", int'(arr_abort), 1);
    arr_busy = 1'b0;
    lat = 0;
    while (!rd_ack && lat < 20) begin @(negedge clk); lat++; end
    check("R10 stalled data", int'(rd_data), int'({16'hF1A5, 16'h00A0}));
    rd_req = 1'b0; irq_clr = 2'b01;
    @(negedge clk);
    irq_clr = 2'b00;
    @(negedge clk);
    check("R11 cleared", int'(irq_abort), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule